// File: doc/BRIEF.md
# Level-Sensitive Interrupt Source Controller

This block gathers sixteen level-sensitive interrupt lines and decides, on every clock, which one should be offered to the downstream presentation controller. Software programs an 8-bit priority for each line through a 32-bit Wishbone register port. Smaller numbers are more urgent. The all-ones value `0xFF` is reserved to mean "masked". Each line's configuration word also shows the raw state of the input in its most significant bit, so software can see a pending request without unmasking it.

The winner is sent out as a 4-bit source number and an 8-bit priority. When no line is both asserted and unmasked, the outgoing priority is `0xFF` and the source number is zero. The presentation controller treats that code as "nothing to deliver". The selection is registered, which gives a fixed one-cycle latency from any input or configuration change.

Top module: `irq_source_ctrl`

## Requirements
- R1: While reset is held and right after it, every source priority is `0xFF`, the presented priority is `0xFF`, the presented source is 0, and the bus acknowledge is low.
- R2: The configuration word for source n sits at byte offset `0x800 + 4*n`. The port carries word addresses (byte offset divided by four), so source n is at word `0x200 + n`. A read returns the priority in bits [7:0], zeros in bits [30:8], and in bit 31 the input level of that source as sampled on the acknowledging access edge.
- R3: A source whose priority is `0xFF` is never presented, even while its input is asserted. Its bit 31 still reads 1.
- R4: Among sources that are asserted and have a priority below `0xFF`, the one with the numerically smallest priority is presented, together with that priority.
- R5: When no source qualifies, the presented priority is `0xFF` and the presented source is 0.
- R6: When several qualifying sources share the smallest priority, the lowest source number is presented.
- R7: Every access with cycle and strobe high is acknowledged by a one-cycle pulse on the clock edge after the strobe is sampled. The acknowledge is never high two cycles in a row.
- R8: A write updates a source's priority from data bits [7:0] only when byte select bit 0 is set. Data bits [31:8] have no effect.
- R9: Words outside the sixteen-entry table read as zero, and writes to them change nothing.
- R10: The presented source and priority reflect the input levels and priorities sampled at the previous clock edge. A change becomes visible exactly one edge later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wb_adr_i | input | 10 | Word address within the 4 KiB register window |
| wb_dat_i | input | 32 | Write data |
| wb_sel_i | input | 4 | Byte selects; bit 0 enables the priority byte |
| wb_cyc_i | input | 1 | Bus cycle active |
| wb_stb_i | input | 1 | Strobe |
| wb_we_i | input | 1 | Write enable |
| wb_dat_o | output | 32 | Read data, valid with the acknowledge |
| wb_ack_o | output | 1 | Acknowledge pulse |
| irq_level_i | input | 16 | Level inputs, one per source |
| pres_src_o | output | 4 | Number of the presented source |
| pres_prio_o | output | 8 | Priority of the presented source, `0xFF` for none |

## Verification
The bench targets the corner cases below. Each one describes how a faulty design would show up.

- **Equal priorities.** Two sources are given the same priority. A design that lets the later source win would present source 5 instead of source 2.
- **Masked but asserted inputs.** All inputs are raised while every source is masked. A design that treats `0xFF` as an ordinary priority would present a masked line instead of the idle code.
- **Partial and out-of-range writes.** Writes go out with byte select 0 cleared, and to words just past the table. A design that ignores the byte select, or wraps the index, would corrupt a live priority and change the presented source.
- **Latency.** A line is dropped and the output is sampled immediately, then again one edge later. This catches a design that is either combinational or one stage too slow.
- **Read-back.** Read-back of bit 31 on a masked source confirms that the level reflects the pin and not the mask.

// File: rtl/irqsrc_pkg.sv
package irqsrc_pkg;

    // Width of one priority field and the code that means "masked / nothing"
    localparam int PRIO_W = 8;
    localparam int SRC_W  = 4;
    localparam logic [PRIO_W-1:0] PRIO_MASKED = '1;

    // Byte offset of the first configuration word inside the register window
    localparam int TABLE_BYTE_BASE = 'h800;

    typedef logic [PRIO_W-1:0] prio_t;

    typedef struct packed {
        logic [SRC_W-1:0] src;
        prio_t            prio;
    } pick_t;

    localparam pick_t PICK_IDLE = '{src: '0, prio: PRIO_MASKED};

    // A line takes part in arbitration only when raised and not masked
    function automatic logic eligible(input logic lvl, input prio_t p);
        return lvl && (p != PRIO_MASKED);
    endfunction

    // Keeps the incumbent on a tie, so scanning upward favours low numbers
    function automatic logic beats(input prio_t challenger, input prio_t incumbent);
        return challenger < incumbent;
    endfunction

endpackage

// File: rtl/irqsrc_cfg_regs.sv
module irqsrc_cfg_regs
    import irqsrc_pkg::*;
#(
    parameter int NUM_SRC = 16,
    parameter int ADDR_W  = 10,
    parameter int DATA_W  = 32
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [ADDR_W-1:0]          wb_adr_i,
    input  logic [DATA_W-1:0]          wb_dat_i,
    input  logic [DATA_W/8-1:0]        wb_sel_i,
    input  logic                       wb_cyc_i,
    input  logic                       wb_stb_i,
    input  logic                       wb_we_i,
    output logic [DATA_W-1:0]          wb_dat_o,
    output logic                       wb_ack_o,
    input  logic [NUM_SRC-1:0]         level_i,
    output prio_t [NUM_SRC-1:0]        prio_o
);

    localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
    localparam logic [ADDR_W-1:0] BASE_WORD = ADDR_W'(TABLE_BYTE_BASE / 4);
    localparam logic [ADDR_W-1:0] ENTRIES   = ADDR_W'(NUM_SRC);

    prio_t [NUM_SRC-1:0] prio_q;
    logic                ack_q;
    logic [DATA_W-1:0]   rdata_q;

    logic [ADDR_W-1:0]   rel_word;
    logic                in_table;
    logic [IDX_W-1:0]    idx;
    logic                take;
    logic [DATA_W-1:0]   rd_word;

    assign rel_word = wb_adr_i - BASE_WORD;
    assign in_table = (wb_adr_i >= BASE_WORD) && (rel_word < ENTRIES);
    assign idx      = rel_word[IDX_W-1:0];
    assign take     = wb_cyc_i && wb_stb_i && !ack_q;

    always_comb begin
        rd_word               = '0;
        rd_word[DATA_W-1]     = level_i[idx];
        rd_word[PRIO_W-1:0]   = prio_q[idx];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ack_q   <= 1'b0;
            rdata_q <= '0;
            for (int i = 0; i < NUM_SRC; i++) begin
                prio_q[i] <= PRIO_MASKED;
            end
        end else begin
            ack_q   <= take;
            rdata_q <= '0;
            if (take) begin
                if (wb_we_i) begin
                    if (in_table && wb_sel_i[0]) begin
                        prio_q[idx] <= wb_dat_i[PRIO_W-1:0];
                    end
                end else if (in_table) begin
                    rdata_q <= rd_word;
                end
            end
        end
    end

    assign wb_ack_o = ack_q;
    assign wb_dat_o = rdata_q;
    assign prio_o   = prio_q;

    logic unused_bits;
    assign unused_bits = ^{wb_dat_i[DATA_W-1:PRIO_W], wb_sel_i[DATA_W/8-1:1]};

    // R7: the acknowledge is a single-cycle pulse
    p_ack_pulse_r7 : assert property (@(posedge clk) disable iff (rst)
        wb_ack_o |=> !wb_ack_o);

    // R7: an acknowledge is always answering a strobe seen one edge earlier
    p_ack_after_stb_r7 : assert property (@(posedge clk) disable iff (rst)
        wb_ack_o |-> $past(wb_cyc_i && wb_stb_i));

    // R8: a write with the low byte lane disabled leaves the table untouched
    p_sel_gate_r8 : assert property (@(posedge clk) disable iff (rst)
        (take && wb_we_i && !wb_sel_i[0]) |=> $stable(prio_q));

endmodule

// File: rtl/irqsrc_select.sv
module irqsrc_select
    import irqsrc_pkg::*;
#(
    parameter int NUM_SRC = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_SRC-1:0]  level_i,
    input  prio_t [NUM_SRC-1:0] prio_i,
    output pick_t               pick_o
);

    pick_t best;
    pick_t pick_q;

    // Upward scan with strict comparison: equal priorities keep the lower number
    always_comb begin
        best = PICK_IDLE;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (eligible(level_i[i], prio_i[i]) && beats(prio_i[i], best.prio)) begin
                best.src  = SRC_W'(i);
                best.prio = prio_i[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pick_q <= PICK_IDLE;
        end else begin
            pick_q <= best;
        end
    end

    assign pick_o = pick_q;

    // R5: the idle code always pairs priority 0xFF with source zero
    p_idle_src_zero_r5 : assert property (@(posedge clk) disable iff (rst)
        (pick_o.prio == PRIO_MASKED) |-> (pick_o.src == '0));

    // R4: a chosen line is raised and carries the priority that is reported
    p_winner_live_r4 : assert property (@(posedge clk) disable iff (rst)
        (best.prio != PRIO_MASKED) |-> (level_i[best.src] && (prio_i[best.src] == best.prio)));

endmodule

// File: rtl/irq_source_ctrl.sv
module irq_source_ctrl
    import irqsrc_pkg::*;
#(
    parameter int NUM_SRC = 16,
    parameter int ADDR_W  = 10,
    parameter int DATA_W  = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [ADDR_W-1:0]    wb_adr_i,
    input  logic [DATA_W-1:0]    wb_dat_i,
    input  logic [DATA_W/8-1:0]  wb_sel_i,
    input  logic                 wb_cyc_i,
    input  logic                 wb_stb_i,
    input  logic                 wb_we_i,
    output logic [DATA_W-1:0]    wb_dat_o,
    output logic                 wb_ack_o,
    input  logic [NUM_SRC-1:0]   irq_level_i,
    output logic [SRC_W-1:0]     pres_src_o,
    output logic [PRIO_W-1:0]    pres_prio_o
);

    prio_t [NUM_SRC-1:0] prio_tab;
    pick_t               pick;

    irqsrc_cfg_regs #(
        .NUM_SRC (NUM_SRC),
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W)
    ) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wb_adr_i (wb_adr_i),
        .wb_dat_i (wb_dat_i),
        .wb_sel_i (wb_sel_i),
        .wb_cyc_i (wb_cyc_i),
        .wb_stb_i (wb_stb_i),
        .wb_we_i  (wb_we_i),
        .wb_dat_o (wb_dat_o),
        .wb_ack_o (wb_ack_o),
        .level_i  (irq_level_i),
        .prio_o   (prio_tab)
    );

    irqsrc_select #(
        .NUM_SRC (NUM_SRC)
    ) u_select (
        .clk     (clk),
        .rst     (rst),
        .level_i (irq_level_i),
        .prio_i  (prio_tab),
        .pick_o  (pick)
    );

    assign pres_src_o  = pick.src;
    assign pres_prio_o = pick.prio;

endmodule

// File: tb/irq_source_ctrl_bench.sv
`timescale 1ns/1ps
module irq_source_ctrl_bench;

    localparam int N = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [9:0]  adr = '0;
    logic [31:0] wdat = '0;
    logic [3:0]  sel = '0;
    logic        cyc = 1'b0, stb = 1'b0, we = 1'b0;
    logic [31:0] rdat;
    logic        ack;
    logic [N-1:0] lev = '0;
    logic [3:0]  psrc;
    logic [7:0]  pprio;

    always #4 clk = ~clk;

    irq_source_ctrl u_irq_source_ctrl (
        .clk (clk), .rst (rst),
        .wb_adr_i (adr), .wb_dat_i (wdat), .wb_sel_i (sel),
        .wb_cyc_i (cyc), .wb_stb_i (stb), .wb_we_i (we),
        .wb_dat_o (rdat), .wb_ack_o (ack),
        .irq_level_i (lev),
        .pres_src_o (psrc), .pres_prio_o (pprio)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // Behavioural reference, advanced at each rising edge
    int          m_prio [N];
    int          e_src, e_prio, bs, bp, k, w;
    bit          e_ack, e_rd, go, hit;
    logic [31:0] e_dat;

    always @(posedge clk) begin
        if (rst) begin
            foreach (m_prio[i]) m_prio[i] = 255;
            e_src = 0; e_prio = 255; e_ack = 0; e_rd = 0; e_dat = '0;
        end else begin
            bs = 0; bp = 255;
            for (int i = 0; i < N; i++)
                if (lev[i] && m_prio[i] != 255 && m_prio[i] < bp) begin bp = m_prio[i]; bs = i; end
            go  = cyc && stb && !e_ack;
            w   = int'(adr);
            hit = (w >= 'h200) && (w < 'h200 + N);
            k   = w - 'h200;
            e_rd  = go && !we;
            e_dat = '0;
            if (go && hit && !we) e_dat = {lev[k], 23'b0, 8'(m_prio[k])};
            if (go && hit && we && sel[0]) m_prio[k] = int'(wdat[7:0]);
            e_ack = go; e_src = bs; e_prio = bp;
        end
    end

    always @(negedge clk) begin
        if (!done) begin
            if (rst) begin
                check("R1", {24'b0, pprio}, 32'hFF);
                check("R1", {28'b0, psrc}, 32'h0);
                check("R1", {31'b0, ack}, 32'h0);
            end else begin
                check((e_prio == 255) ? "R5" : "R4", {24'b0, pprio}, e_prio);
                check((e_prio == 255) ? "R5" : "R4", {28'b0, psrc}, e_src);
                check("R7", {31'b0, ack}, {31'b0, e_ack});
                if (e_ack && e_rd) check("R2", rdat, e_dat);
            end
        end
    end

    task automatic bus_wr(input int word, input logic [31:0] d, input logic [3:0] s);
        @(negedge clk);
        adr = 10'(word); wdat = d; sel = s; we = 1; cyc = 1; stb = 1;
        @(negedge clk);
        cyc = 0; stb = 0; we = 0;
    endtask

    task automatic bus_rd(input int word, output logic [31:0] q);
        @(negedge clk);
        adr = 10'(word); sel = 4'hF; we = 0; cyc = 1; stb = 1;
        @(negedge clk);
        q = rdat;
        cyc = 0; stb = 0;
    endtask

    task automatic finish_run;
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        #(8 * 150000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] q;
        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk);
        check("R1", {24'b0, pprio}, 32'hFF);
        bus_rd('h200, q);
        check("R1", q, 32'h0000_00FF);

        // R3: every line raised while all are masked
        lev = '1;
        repeat (2) @(negedge clk);
        check("R3", {24'b0, pprio}, 32'hFF);
        bus_rd('h203, q);
        check("R3", q, 32'h8000_00FF);

        // R6: equal priorities, lower number wins
        bus_wr('h205, 32'h10, 4'hF);
        bus_wr('h202, 32'h10, 4'hF);
        @(negedge clk);
        check("R6", {28'b0, psrc}, 32'd2);
        check("R6", {24'b0, pprio}, 32'h10);

        // R4 and R8: upper data ignored
        bus_wr('h209, 32'hABCD_EF05, 4'h1);
        @(negedge clk);
        check("R4", {28'b0, psrc}, 32'd9);
        bus_rd('h209, q);
        check("R8", q, 32'h8000_0005);

        // R8: byte lane 0 disabled, no change
        bus_wr('h209, 32'h01, 4'hE);
        @(negedge clk);
        check("R8", {24'b0, pprio}, 32'h05);

        // R9: words outside the table
        bus_wr('h210, 32'h00, 4'hF);
        bus_wr('h000, 32'h00, 4'hF);
        bus_rd('h210, q);
        check("R9", q, 32'h0);
        bus_rd('h1FF, q);
        check("R9", q, 32'h0);
        @(negedge clk);
        check("R9", {28'b0, psrc}, 32'd9);

        // R10: one-edge latency after dropping the winner
        lev[9] = 1'b0;
        #1;
        check("R10", {28'b0, psrc}, 32'd9);
        @(negedge clk);
        check("R10", {28'b0, psrc}, 32'd2);
        check("R10", {24'b0, pprio}, 32'h10);

        // R5: nothing raised
        lev = '0;
        repeat (2) @(negedge clk);
        check("R5", {24'b0, pprio}, 32'hFF);
        check("R5", {28'b0, psrc}, 32'd0);

        // R3: remask a line and raise only it
        bus_wr('h202, 32'hFF, 4'hF);
        lev = 16'h0004;
        repeat (2) @(negedge clk);
        check("R3", {24'b0, pprio}, 32'hFF);

        // Mixed traffic compared against the reference on every edge
        for (int it = 0; it < 600; it++) begin
            int r;
            r = int'($urandom_range(0, 9));
            if (r < 3) begin
                bus_wr(int'($urandom_range('h1FE, 'h212)), {$urandom_range(0, 255), 8'($urandom_range(0, 255))},
                       4'($urandom_range(0, 15)));
            end else if (r < 5) begin
                bus_rd(int'($urandom_range('h1FE, 'h212)), q);
            end else begin
                @(negedge clk);
                lev = 16'($urandom);
            end
        end
        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule